// File: doc/BRIEF.md
# Fragmenting Timed Channel

This block stands between two units of an emulated system and models the one-way link that joins them, with timing counted in target cycles rather than in host clock cycles. A sender hands over whole messages of `MSG_W` bits. The channel cuts each message into slices of `FRAG_W` bits and sends at most one slice in each target cycle. Each slice is delayed by `LATENCY` target cycles and then stored in a buffer that holds `BUF_FRAGS` slices. At the far end the slices are joined back into the original message, which is offered to the receiver with a valid/ready handshake.

Target time moves forward only when the `tick` strobe is high. In each tick the channel carries either one slice, marked with valid and last-slice flags, or an empty slot. An empty slot moves through the delay stages exactly as a data slot does, so idle target cycles still count as time. When the last slice does not fill all of its bits, the unused high bits are set to zero and are dropped again when the message is rebuilt. A credit counter counts every slice that has been launched and not yet removed from the buffer. The sender can only launch a slice while that count is below the buffer capacity, so a receiver that stops accepting messages slows down the sender.

The fragmenter has two states. In F_IDLE it accepts a message, taking the transition F_IDLE→F_SEND. In F_SEND it launches one slice per tick while credit remains, and the last slice takes it along F_SEND→F_IDLE. The reassembler also has two states. In A_COLLECT it pulls slices from the buffer, and a slice flagged last takes it along A_COLLECT→A_PRESENT. In A_PRESENT it holds the message, and acceptance by the receiver takes it along A_PRESENT→A_COLLECT.

Top module: `timed_frag_channel`

## Requirements
- R1: Messages come out in the order they were accepted, each bit-identical to the message that was sent.
- R2: Each message is sent as ceil(MSG_W/FRAG_W) slices, least significant slice first. The high bits of the last slice that lie beyond MSG_W are zero on the channel and are removed on output.
- R3: On an empty channel with the receiver ready, `out_valid` first rises after exactly ceil(MSG_W/FRAG_W)+LATENCY ticks have occurred after the acceptance edge. It rises before the next tick, provided ticks are at least three clocks apart.
- R4: While `tick` is low, no slice moves. A message that has been accepted never reaches the output, no matter how many host cycles pass.
- R5: The number of slices that have been launched and not yet taken from the buffer never exceeds BUF_FRAGS. When the receiver stalls, the sender is held off once that limit is reached.
- R6: `in_ready` is high only while no message is being sliced. A message is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R7: Once `out_valid` is high, it stays high and `out_data` stays unchanged until `out_ready` is high.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Target-cycle advance strobe, one host cycle wide |
| in_valid | input | 1 | Sender offers a message |
| in_ready | output | 1 | Channel can accept a message |
| in_data | input | MSG_W | Message from the sender |
| out_valid | output | 1 | Rebuilt message available |
| out_ready | input | 1 | Receiver accepts the message |
| out_data | output | MSG_W | Rebuilt message |

## Verification
The bench builds the block with MSG_W=20, FRAG_W=8, LATENCY=3 and BUF_FRAGS=4, and pulses `tick` once every four clocks. With these values every message becomes three slices, and the last slice carries four padding bits, so padding and its removal are exercised on every message. The small buffer means a stalled receiver fills the credit window after only two and a third messages. At that point exactly three messages have been accepted and the fourth is refused, which makes the backpressure limit observable at the ports. The latency of three ticks plus three slices gives an expected arrival of six ticks after acceptance. Because this is short, the bench can place that check between ticks with cycle accuracy.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    typedef enum logic {F_IDLE, F_SEND} frag_state_e;
    typedef enum logic {A_COLLECT, A_PRESENT} asm_state_e;
endpackage

// File: rtl/tfc_fragmenter.sv
module tfc_fragmenter
    import tfc_pkg::*;
#(
    parameter int MSG_W  = 32,
    parameter int FRAG_W = 8,
    parameter int NFRAG  = (MSG_W + FRAG_W - 1) / FRAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              credit_ok,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MSG_W-1:0]  in_data,
    output logic              slot_valid,
    output logic              slot_last,
    output logic [FRAG_W-1:0] slot_data,
    output logic              issue
);
    localparam int PAD_W = NFRAG * FRAG_W;
    localparam int IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1;

    frag_state_e      state_q, state_d;
    logic [PAD_W-1:0] msg_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: if (accept) state_d = F_SEND;
            F_SEND: if (issue && slot_last) state_d = F_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_ready   = (state_q == F_IDLE);
        accept     = in_valid && in_ready;
        slot_valid = (state_q == F_SEND) && credit_ok;
        slot_last  = (idx_q == IDX_W'(NFRAG - 1));
        slot_data  = msg_q[FRAG_W-1:0];
        issue      = tick && slot_valid;
    end

    // datapath: lowest slice first, zero-fill from the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q <= '0;
            idx_q <= '0;
        end else if (accept) begin
            msg_q <= PAD_W'(in_data);
            idx_q <= '0;
        end else if (issue) begin
            msg_q <= msg_q >> FRAG_W;
            idx_q <= idx_q + 1'b1;
        end
    end

    // R6
    // the slice flagged last ends slicing and reopens the sender side
    last_closes_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && slot_last |=> in_ready);

    generate
        if (PAD_W > MSG_W) begin : g_padchk
            // R2
            // padding bits of the final slice are zero
            pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                issue && slot_last |-> slot_data[FRAG_W-1 -: (PAD_W-MSG_W)] == '0);
        end
    endgenerate
endmodule

// File: rtl/tfc_delay_line.sv
module tfc_delay_line #(
    parameter int SW      = 10,
    parameter int LATENCY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [SW-1:0] in_slot,
    output logic [SW-1:0] out_slot
);
    logic [SW-1:0] stg [LATENCY];

    generate
        for (genvar g = 0; g < LATENCY; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n)    stg[g] <= '0;
                    else if (tick) stg[g] <= in_slot;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n)    stg[g] <= '0;
                    else if (tick) stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign out_slot = stg[LATENCY-1];

    // R4
    // target time frozen without a strobe
    frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_slot));
endmodule

// File: rtl/tfc_buffer.sv
module tfc_buffer #(
    parameter int DW    = 9,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= nxt(wp_q);
            if (rd_en) rp_q <= nxt(rp_q);
            if (wr_en && !rd_en)      cnt_q <= cnt_q + 1'b1;
            else if (rd_en && !wr_en) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q] <= wr_data;
    end

    assign rd_data = mem[rp_q];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));

    // R5
    // credit scheme must keep arrivals within the storage
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && full && !rd_en));

    // R1
    // reads only from held entries
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && empty));
endmodule

// File: rtl/tfc_reassembler.sv
module tfc_reassembler
    import tfc_pkg::*;
#(
    parameter int MSG_W  = 32,
    parameter int FRAG_W = 8,
    parameter int NFRAG  = (MSG_W + FRAG_W - 1) / FRAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_avail,
    input  logic              frag_last,
    input  logic [FRAG_W-1:0] frag_data,
    output logic              pop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [MSG_W-1:0]  out_data
);
    localparam int PAD_W = NFRAG * FRAG_W;

    asm_state_e       state_q, state_d;
    logic [PAD_W-1:0] asm_q, asm_shift;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A_COLLECT: if (pop && frag_last) state_d = A_PRESENT;
            A_PRESENT: if (out_ready)        state_d = A_COLLECT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= A_COLLECT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pop       = (state_q == A_COLLECT) && frag_avail;
        out_valid = (state_q == A_PRESENT);
        out_data  = asm_q[MSG_W-1:0];
    end

    generate
        if (NFRAG > 1) begin : g_multi
            assign asm_shift = {frag_data, asm_q[PAD_W-1:FRAG_W]};
        end else begin : g_single
            assign asm_shift = frag_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)   asm_q <= '0;
        else if (pop) asm_q <= asm_shift;
    end

    // R7
    // an offered message is held until taken
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    generate
        if (PAD_W > MSG_W) begin : g_padchk
            // R2
            // rebuilt padding is all zero, so dropping it loses nothing
            pad_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> asm_q[PAD_W-1:MSG_W] == '0);
        end
    endgenerate
endmodule

// File: rtl/timed_frag_channel.sv
module timed_frag_channel
    import tfc_pkg::*;
#(
    parameter int MSG_W     = 32,
    parameter int FRAG_W    = 8,
    parameter int LATENCY   = 3,
    parameter int BUF_FRAGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MSG_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [MSG_W-1:0] out_data
);
    localparam int NFRAG = (MSG_W + FRAG_W - 1) / FRAG_W;
    localparam int SW    = FRAG_W + 2;
    localparam int OCC_W = $clog2(BUF_FRAGS + 1);

    logic              credit_ok, issue, pop;
    logic              s_valid, s_last;
    logic [FRAG_W-1:0] s_data;
    logic [SW-1:0]     far_slot;
    logic [FRAG_W:0]   buf_rd;
    logic              buf_empty, buf_full;
    logic [OCC_W-1:0]  occ_q;

    // credits: slices launched and not yet pulled from the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)               occ_q <= '0;
        else if (issue && !pop)   occ_q <= occ_q + 1'b1;
        else if (pop && !issue)   occ_q <= occ_q - 1'b1;
    end
    assign credit_ok = (occ_q < OCC_W'(BUF_FRAGS));

    tfc_fragmenter #(.MSG_W(MSG_W), .FRAG_W(FRAG_W), .NFRAG(NFRAG)) u_frag (
        .clk(clk), .rst_n(rst_n), .tick(tick), .credit_ok(credit_ok),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .slot_valid(s_valid), .slot_last(s_last), .slot_data(s_data),
        .issue(issue)
    );

    tfc_delay_line #(.SW(SW), .LATENCY(LATENCY)) u_delay (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .in_slot({s_valid, s_last, s_data}),
        .out_slot(far_slot)
    );

    tfc_buffer #(.DW(FRAG_W + 1), .DEPTH(BUF_FRAGS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tick && far_slot[SW-1]),
        .wr_data(far_slot[FRAG_W:0]),
        .rd_en(pop), .rd_data(buf_rd),
        .empty(buf_empty), .full(buf_full)
    );

    tfc_reassembler #(.MSG_W(MSG_W), .FRAG_W(FRAG_W), .NFRAG(NFRAG)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .frag_avail(!buf_empty), .frag_last(buf_rd[FRAG_W]),
        .frag_data(buf_rd[FRAG_W-1:0]), .pop(pop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // R5
    // outstanding slices bounded by capacity
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(BUF_FRAGS));

    // R5
    // a full buffer implies every credit is spent
    full_means_no_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !credit_ok);
endmodule

// File: tb/timed_frag_channel_test.sv
module timed_frag_channel_test;
    localparam int MSG_W = 20, FRAG_W = 8, LAT = 3, BUFN = 4;
    localparam int NFRAG = (MSG_W + FRAG_W - 1) / FRAG_W;
    localparam int TICK_P = 4;

    logic clk = 0, rst_n = 0, tick, tick_en = 0;
    logic in_valid = 0, out_ready = 0;
    logic [MSG_W-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [MSG_W-1:0] out_data;

    int checks = 0, errors = 0, tcount = 0, tphase = 0, accepted = 0, delivered = 0;
    logic [MSG_W-1:0] expq [$];

    always #10 clk = ~clk;

    timed_frag_channel #(.MSG_W(MSG_W), .FRAG_W(FRAG_W), .LATENCY(LAT), .BUF_FRAGS(BUFN)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    assign tick = tick_en && (tphase == 0);
    always @(posedge clk) begin
        tphase <= (tphase == TICK_P - 1) ? 0 : tphase + 1;
        if (tick) tcount <= tcount + 1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: offers one message and logs it on acceptance
    task automatic send(input logic [MSG_W-1:0] m);
        @(posedge clk); #2;
        in_valid = 1; in_data = m;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #2;
        expq.push_back(m);
        accepted++;
        in_valid = 0;
    endtask

    // monitor: compares each handshake against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(0, "R1 unexpected message", out_data, 0);
            end else begin
                check(out_data == expq[0], "R1 data/order", out_data, expq[0]);
                void'(expq.pop_front());
            end
            delivered++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", delivered, accepted);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || out_valid) && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [MSG_W-1:0] held;
        int t0;
        repeat (3) @(posedge clk); #2;
        rst_n = 1;
        @(negedge clk);
        // R8
        check(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R8 in_ready after reset", in_ready, 1);

        // R4: no ticks, nothing moves
        send(20'hABCDE);
        repeat (40) @(negedge clk);
        check(out_valid == 0, "R4 frozen output", out_valid, 0);
        // R6: busy slicing, so not ready
        check(in_ready == 0, "R6 ready while slicing", in_ready, 0);
        out_ready = 1; tick_en = 1;
        drain();
        check(delivered == 1, "R4 delivered once ticks run", delivered, 1);

        // R3: latency in ticks on an empty channel
        @(posedge clk); #2;
        in_valid = 1; in_data = 20'h13579;
        forever begin @(negedge clk); if (in_ready) break; end
        @(posedge clk); #2;
        in_valid = 0; expq.push_back(20'h13579); accepted++;
        t0 = tcount;
        while (!out_valid) @(negedge clk);
        check(tcount - t0 == NFRAG + LAT, "R3 ticks to arrival", tcount - t0, NFRAG + LAT);
        drain();

        // R2: all-ones and single-bit patterns survive padding
        send(20'hFFFFF);
        send(20'h80000);
        send(20'h00001);
        drain();
        check(delivered == 5, "R2 pattern messages delivered", delivered, 5);

        // R5/R7: stalled receiver
        out_ready = 0;
        fork
            begin
                send(20'h11111); send(20'h22222); send(20'h33333); send(20'h44444);
            end
        join_none
        repeat (200) @(negedge clk);
        check(accepted == 8, "R5 accepted under stall", accepted, 8);
        check(in_ready == 0, "R5 sender held off", in_ready, 0);
        check(out_valid == 1, "R7 offer held", out_valid, 1);
        held = out_data;
        check(held == 20'h11111, "R7 offered data", held, 20'h11111);
        repeat (60) @(negedge clk);
        check(out_valid == 1 && out_data == held, "R7 stable while stalled", out_data, held);
        out_ready = 1;
        wait (accepted == 9);
        drain();
        check(delivered == 9, "R1 all stalled messages delivered", delivered, 9);

        // R1: stream with a toggling receiver
        fork
            for (int i = 0; i < 12; i++) send(MSG_W'(32'h9E37 * (i + 3) ^ (i << 11)));
            for (int k = 0; k < 300; k++) begin
                @(posedge clk); #3;
                out_ready = (k % 5) != 2;
            end
        join
        out_ready = 1;
        drain();
        check(delivered == 21 && expq.size() == 0, "R1 stream complete", delivered, 21);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule